// File: doc/BRIEF.md
# LCD Bias Waveform Generator

This block drives a multiplexed liquid-crystal panel arranged as 4 common lines by 18 segment lines, so up to 72 segments can be lit. It runs at quarter duty with a selectable 1/2 or 1/3 bias. Every common and segment output is a 3-bit level code that picks one analog bias rail. The codes are 0 = GND, 1 = 1/3 VDD, 2 = 1/2 VDD, 3 = 2/3 VDD and 4 = VDD. An analog stage outside this block turns the codes into voltages.

A drive frame has 8 steps, and each rising edge of `clk` with `step_tick` high advances one step. With a 2 ms tick the frame lasts 16 ms, which is a 62.5 Hz frame rate. In step `s`, common `s>>1` is the selected line and bit 0 of `s` gives the polarity (0 = positive, 1 = negative). Each common is therefore selected once in each polarity, and the drive carries no net DC.

The host loads a new segment map and bias choice with a write strobe. The block holds these values as pending and applies them only at a frame boundary. The `disp_off` level is also sampled only at a frame boundary. While it is in effect, a whole frame of the non-selected waveform is shown.

The control core is a state machine with three states:
- `ST_BLANK`: the state after reset. It shows the non-selected waveform at positive polarity.
- `ST_SCAN`: normal scanning.
- `ST_OFF`: display off. It shows the non-selected waveform, and the step count keeps running.

The named transitions are:
- T_START: `ST_BLANK` to `ST_SCAN` on the first tick while `disp_off` is low.
- T_BLANK_OFF: `ST_BLANK` to `ST_OFF` on the first tick while `disp_off` is high.
- T_SHUT: `ST_SCAN` to `ST_OFF` at a frame boundary while `disp_off` is high.
- T_WAKE: `ST_OFF` to `ST_SCAN` at a frame boundary while `disp_off` is low.
- T_STEP: a self-loop in `ST_SCAN` or `ST_OFF` on any tick that is not a boundary.

Top module: `lcd_bias_gen`

## Requirements
- R1: During and after reset, until the first tick, every common outputs code 2 and every segment outputs code 4. This is the non-selected waveform in 1/2 bias at positive polarity, and the reset bias is 1/2.
- R2: The first tick after reset starts a frame at step 0. Each later tick advances the step by one, and the tick taken at step 7 returns it to step 0. In step s, common s>>1 is selected and bit 0 of s is the polarity (1 = negative).
- R3: While scanning, the selected common outputs code 4 (VDD) in positive polarity and code 0 (GND) in negative polarity.
- R4: Non-selected commons output code 2 in 1/2 bias. In 1/3 bias they output code 1 in positive polarity and code 3 in negative polarity.
- R5: While scanning, a segment whose map bit (bit index seg*4 + com, for the selected common) is 1 outputs the level opposite to the selected common: code 0 in positive polarity and code 4 in negative polarity.
- R6: A segment that is not lit outputs code 4 in positive polarity and code 0 in negative polarity in 1/2 bias. In 1/3 bias it outputs code 3 in positive polarity and code 1 in negative polarity.
- R7: Every output code is in the range 0 to 4. In 1/2 bias the commons use only codes 0, 2 and 4, and the segments use only codes 0 and 4.
- R8: A map and bias written with `cfg_wr` have no effect on the outputs until a frame boundary. A frame boundary is the first tick after reset or the tick taken at step 7.
- R9: `disp_off` is sampled only at a frame boundary. While it is in effect, for a whole frame, every common shows its non-selected level and every segment shows its unlit level for the current polarity, and the step count keeps advancing.
- R10: The outputs change only at a clock edge where `step_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_tick | input | 1 | Advance one drive step |
| cfg_wr | input | 1 | Write strobe for the pending map and bias |
| cfg_seg_map | input | 72 | Segment map, bit seg*4+com |
| cfg_bias_third | input | 1 | 1 = 1/3 bias, 0 = 1/2 bias |
| disp_off | input | 1 | Display-off request, sampled at frame boundaries |
| com_lvl | output | 12 | Common level codes, 3 bits per common, common 0 in the low bits |
| seg_lvl | output | 54 | Segment level codes, 3 bits per segment, segment 0 in the low bits |

## Verification
The outputs are decoded combinationally from registered state. A tick sampled at a rising edge therefore shows its new step at that same edge, and a map write or a `disp_off` change shows only at the boundary tick that follows. The bench drives every input at a falling edge and compares all 22 outputs at the next falling edge against a model that it advances at the rising edge where it raised the tick. Idle cycles and writes made in the middle of a frame are checked in the same way, which confirms that nothing moves without a tick.

// File: rtl/lcd_bias_pkg.sv
package lcd_bias_pkg;

    localparam int LVL_W = 3;

    typedef enum logic [LVL_W-1:0] {
        LVL_GND      = 3'd0,
        LVL_THIRD    = 3'd1,
        LVL_HALF     = 3'd2,
        LVL_TWOTHIRD = 3'd3,
        LVL_VDD      = 3'd4
    } lvl_e;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_SCAN  = 2'd1,
        ST_OFF   = 2'd2
    } drv_state_e;

    // Level of the common currently being addressed.
    function automatic lvl_e sel_com_lvl(input logic neg);
        return neg ? LVL_GND : LVL_VDD;
    endfunction

    // Level of a common that is not addressed in this step.
    function automatic lvl_e idle_com_lvl(input logic third, input logic neg);
        if (!third) return LVL_HALF;
        return neg ? LVL_TWOTHIRD : LVL_THIRD;
    endfunction

    // Lit segment: opposite rail to the addressed common.
    function automatic lvl_e lit_seg_lvl(input logic neg);
        return neg ? LVL_VDD : LVL_GND;
    endfunction

    // Unlit segment level.
    function automatic lvl_e dark_seg_lvl(input logic third, input logic neg);
        if (!third) return neg ? LVL_GND : LVL_VDD;
        return neg ? LVL_THIRD : LVL_TWOTHIRD;
    endfunction

endpackage

// File: rtl/lcd_step_fsm.sv
module lcd_step_fsm
    import lcd_bias_pkg::*;
#(
    parameter int SW   = 3,
    parameter int LAST = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          off_req,
    output drv_state_e    state_q,
    output logic [SW-1:0] step_q,
    output logic          frame_load
);

    drv_state_e    state_d;
    logic [SW-1:0] step_d;
    logic          at_last;

    assign at_last = (step_q == SW'(LAST));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // Next state, step and boundary strobe
    always_comb begin
        state_d    = state_q;
        step_d     = step_q;
        frame_load = 1'b0;
        unique case (state_q)
            ST_BLANK: begin
                if (tick) begin
                    // T_START / T_BLANK_OFF: frame begins at step 0
                    frame_load = 1'b1;
                    state_d    = off_req ? ST_OFF : ST_SCAN;
                end
            end
            ST_SCAN, ST_OFF: begin
                if (tick) begin
                    if (at_last) begin
                        // T_SHUT / T_WAKE decided at the boundary
                        frame_load = 1'b1;
                        step_d     = '0;
                        state_d    = off_req ? ST_OFF : ST_SCAN;
                    end else begin
                        // T_STEP
                        step_d = step_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_BLANK;
                step_d  = '0;
            end
        endcase
    end

endmodule

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow #(
    parameter int MAP_W = 72
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [MAP_W-1:0] cfg_map,
    input  logic             cfg_third,
    input  logic             frame_load,
    output logic [MAP_W-1:0] act_map,
    output logic             act_third
);

    logic [MAP_W-1:0] pend_map;
    logic             pend_third;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_map   <= '0;
            pend_third <= 1'b0;
        end else if (cfg_wr) begin
            pend_map   <= cfg_map;
            pend_third <= cfg_third;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_map   <= '0;
            act_third <= 1'b0;
        end else if (frame_load) begin
            act_map   <= pend_map;
            act_third <= pend_third;
        end
    end

endmodule

// File: rtl/lcd_level_mux.sv
module lcd_level_mux
    import lcd_bias_pkg::*;
#(
    parameter int NUM_COM = 4,
    parameter int NUM_SEG = 18,
    parameter int CW      = 2,
    parameter int SW      = 3
) (
    input  drv_state_e                   state_q,
    input  logic [SW-1:0]                step_q,
    input  logic [NUM_COM*NUM_SEG-1:0]   act_map,
    input  logic                         act_third,
    output logic [NUM_COM*LVL_W-1:0]     com_lvl,
    output logic [NUM_SEG*LVL_W-1:0]     seg_lvl
);

    logic          neg;
    logic          scan;
    logic [CW-1:0] acom;
    lvl_e          c_sel, c_idle, s_lit, s_dark;

    // Output process: phase decode and the four candidate levels
    always_comb begin
        neg    = step_q[0];
        scan   = (state_q == ST_SCAN);
        acom   = step_q[SW-1:1];
        c_sel  = sel_com_lvl(neg);
        c_idle = idle_com_lvl(act_third, neg);
        s_lit  = lit_seg_lvl(neg);
        s_dark = dark_seg_lvl(act_third, neg);
    end

    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        assign com_lvl[c*LVL_W +: LVL_W] =
            (scan && (acom == CW'(c))) ? c_sel : c_idle;
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [NUM_COM-1:0] row;
        assign row = act_map[s*NUM_COM +: NUM_COM];
        assign seg_lvl[s*LVL_W +: LVL_W] = (scan && row[acom]) ? s_lit : s_dark;
    end

endmodule

// File: rtl/lcd_bias_gen.sv
module lcd_bias_gen
    import lcd_bias_pkg::*;
#(
    parameter int NUM_COM = 4,
    parameter int NUM_SEG = 18
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         step_tick,
    input  logic                         cfg_wr,
    input  logic [NUM_COM*NUM_SEG-1:0]   cfg_seg_map,
    input  logic                         cfg_bias_third,
    input  logic                         disp_off,
    output logic [NUM_COM*LVL_W-1:0]     com_lvl,
    output logic [NUM_SEG*LVL_W-1:0]     seg_lvl
);

    localparam int CW    = (NUM_COM > 1) ? $clog2(NUM_COM) : 1;
    localparam int SW    = CW + 1;
    localparam int LAST  = 2 * NUM_COM - 1;
    localparam int MAP_W = NUM_COM * NUM_SEG;

    drv_state_e       state_q;
    logic [SW-1:0]    step_q;
    logic             frame_load;
    logic [MAP_W-1:0] act_map;
    logic             act_third;

    lcd_step_fsm #(.SW(SW), .LAST(LAST)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (step_tick),
        .off_req    (disp_off),
        .state_q    (state_q),
        .step_q     (step_q),
        .frame_load (frame_load)
    );

    lcd_cfg_shadow #(.MAP_W(MAP_W)) shadow_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_map    (cfg_seg_map),
        .cfg_third  (cfg_bias_third),
        .frame_load (frame_load),
        .act_map    (act_map),
        .act_third  (act_third)
    );

    lcd_level_mux #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .CW(CW), .SW(SW)) mux_i (
        .state_q   (state_q),
        .step_q    (step_q),
        .act_map   (act_map),
        .act_third (act_third),
        .com_lvl   (com_lvl),
        .seg_lvl   (seg_lvl)
    );

endmodule

// File: rtl/lcd_bias_chk.sv
module lcd_bias_chk
    import lcd_bias_pkg::*;
#(
    parameter int NUM_COM = 4,
    parameter int NUM_SEG = 18,
    parameter int SW      = 3,
    parameter int LAST    = 7
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       step_tick,
    input drv_state_e                 state_q,
    input logic [SW-1:0]              step_q,
    input logic                       frame_load,
    input logic [NUM_COM*NUM_SEG-1:0] act_map,
    input logic                       act_third,
    input logic [NUM_COM*LVL_W-1:0]   com_lvl,
    input logic [NUM_SEG*LVL_W-1:0]   seg_lvl
);

    logic [NUM_COM-1:0] rail_mask;
    logic               codes_ok;

    always_comb begin
        codes_ok = 1'b1;
        for (int c = 0; c < NUM_COM; c++) begin
            rail_mask[c] = (com_lvl[c*LVL_W +: LVL_W] == LVL_VDD) ||
                           (com_lvl[c*LVL_W +: LVL_W] == LVL_GND);
            if (com_lvl[c*LVL_W +: LVL_W] > 3'd4) codes_ok = 1'b0;
            if (!act_third && com_lvl[c*LVL_W +: LVL_W] != LVL_HALF && !rail_mask[c])
                codes_ok = 1'b0;
        end
        for (int s = 0; s < NUM_SEG; s++) begin
            if (seg_lvl[s*LVL_W +: LVL_W] > 3'd4) codes_ok = 1'b0;
            if (!act_third && seg_lvl[s*LVL_W +: LVL_W] != LVL_VDD &&
                seg_lvl[s*LVL_W +: LVL_W] != LVL_GND)
                codes_ok = 1'b0;
        end
    end

    assert_one_rail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> ($countones(rail_mask) == 1));

    assert_blank_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SCAN) |-> (rail_mask == '0));

    assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && state_q != ST_BLANK) |=>
        (step_q == (($past(step_q) == SW'(LAST)) ? '0 : $past(step_q) + 1'b1)));

    assert_hold_config_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> ($stable(act_map) && $stable(act_third)));

    assert_legal_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        codes_ok);

    assert_no_tick_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step_tick) |-> ($stable(com_lvl) && $stable(seg_lvl)));

endmodule

bind lcd_bias_gen lcd_bias_chk #(
    .NUM_COM (NUM_COM),
    .NUM_SEG (NUM_SEG),
    .SW      (SW),
    .LAST    (LAST)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_tick  (step_tick),
    .state_q    (state_q),
    .step_q     (step_q),
    .frame_load (frame_load),
    .act_map    (act_map),
    .act_third  (act_third),
    .com_lvl    (com_lvl),
    .seg_lvl    (seg_lvl)
);

// File: tb/lcd_bias_gen_tb_top.sv
module lcd_bias_gen_tb_top;

    localparam int NC = 4;
    localparam int NS = 18;
    localparam int NB = NC * NS;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            step_tick;
    logic            cfg_wr;
    logic [NB-1:0]   cfg_seg_map;
    logic            cfg_bias_third;
    logic            disp_off;
    logic [NC*3-1:0] com_lvl;
    logic [NS*3-1:0] seg_lvl;

    always #5 clk = ~clk;

    lcd_bias_gen #(.NUM_COM(NC), .NUM_SEG(NS)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .step_tick      (step_tick),
        .cfg_wr         (cfg_wr),
        .cfg_seg_map    (cfg_seg_map),
        .cfg_bias_third (cfg_bias_third),
        .disp_off       (disp_off),
        .com_lvl        (com_lvl),
        .seg_lvl        (seg_lvl)
    );

    int checks = 0;
    int errors = 0;

    // Reference model: mode 0 blank, 1 scan, 2 off
    int            m_mode;
    int            m_step;
    logic [NB-1:0] m_pend, m_act;
    logic          m_pthird, m_athird;

    function automatic int exp_com(int c);
        bit neg = (m_step % 2) == 1;
        if (m_mode == 1 && c == m_step / 2) return neg ? 0 : 4;
        if (!m_athird) return 2;
        return neg ? 3 : 1;
    endfunction

    function automatic int exp_seg(int s);
        bit neg = (m_step % 2) == 1;
        if (m_mode == 1 && m_act[s*NC + m_step/2]) return neg ? 4 : 0;
        if (!m_athird) return neg ? 0 : 4;
        return neg ? 1 : 3;
    endfunction

    task automatic check_all(string ctx);
        int  bad;
        int  got;
        bit  legal;
        // commons: R2 R3 R4
        bad = -1;
        for (int c = 0; c < NC; c++) begin
            got = int'(com_lvl[c*3 +: 3]);
            if (bad < 0 && got != exp_com(c)) bad = c;
        end
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL [%s] R2,R3,R4 com%0d got %0d exp %0d step %0d",
                     ctx, bad, com_lvl[bad*3 +: 3], exp_com(bad), m_step);
        end
        // segments: R5 R6
        bad = -1;
        for (int s = 0; s < NS; s++) begin
            got = int'(seg_lvl[s*3 +: 3]);
            if (bad < 0 && got != exp_seg(s)) bad = s;
        end
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL [%s] R5,R6 seg%0d got %0d exp %0d step %0d",
                     ctx, bad, seg_lvl[bad*3 +: 3], exp_seg(bad), m_step);
        end
        // legality: R7
        legal = 1'b1;
        for (int c = 0; c < NC; c++) begin
            got = int'(com_lvl[c*3 +: 3]);
            if (got > 4 || (!m_athird && got != 0 && got != 2 && got != 4)) legal = 1'b0;
        end
        for (int s = 0; s < NS; s++) begin
            got = int'(seg_lvl[s*3 +: 3]);
            if (got > 4 || (!m_athird && got != 0 && got != 4)) legal = 1'b0;
        end
        checks++;
        if (!legal) begin
            errors++;
            $display("FAIL [%s] R7 illegal code got com=%h seg=%h exp codes within set",
                     ctx, com_lvl, seg_lvl);
        end
    endtask

    task automatic frame_boundary();
        m_act    = m_pend;
        m_athird = m_pthird;
        m_mode   = disp_off ? 2 : 1;
    endtask

    task automatic tick_once();
        step_tick = 1'b1;
        @(posedge clk);
        if (m_mode == 0) begin
            frame_boundary();
        end else if (m_step == 2*NC - 1) begin
            m_step = 0;
            frame_boundary();
        end else begin
            m_step++;
        end
        @(negedge clk);
        step_tick = 1'b0;
    endtask

    task automatic cfg_write(logic [NB-1:0] map, logic third);
        cfg_wr         = 1'b1;
        cfg_seg_map    = map;
        cfg_bias_third = third;
        @(posedge clk);
        m_pend   = map;
        m_pthird = third;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NB-1:0] rand_map();
        logic [95:0] r;
        r = {$urandom, $urandom, $urandom};
        return r[NB-1:0];
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL R2 watchdog expired got hang exp completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1cd7));
        rst_n          = 1'b0;
        step_tick      = 1'b0;
        cfg_wr         = 1'b0;
        cfg_seg_map    = '0;
        cfg_bias_third = 1'b0;
        disp_off       = 1'b0;
        m_mode = 0; m_step = 0;
        m_pend = '0; m_act = '0; m_pthird = 1'b0; m_athird = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        idle(2);
        check_all("R1 after reset");

        // R8 / R10: write before the first tick does not show
        cfg_write(rand_map(), 1'b0);
        idle(3);
        check_all("R8 R10 write while blank");

        // R2: first tick starts the frame; walk a full frame in 1/2 bias
        for (int i = 0; i < 8; i++) begin
            tick_once();
            check_all("R2 frame half bias");
            idle(2);
            check_all("R10 idle between ticks");
        end

        // R8: mid-frame write switches to 1/3 bias only at the boundary
        tick_once(); tick_once(); tick_once();
        cfg_write(rand_map(), 1'b1);
        check_all("R8 mid-frame write");
        for (int i = 0; i < 8; i++) begin
            tick_once();
            check_all("R8 R4 R6 toward boundary");
        end

        // Corner maps: all lit and all dark
        cfg_write('1, 1'b1);
        for (int i = 0; i < 16; i++) begin
            tick_once();
            check_all("R5 all lit");
        end
        cfg_write('0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            tick_once();
            check_all("R6 all dark");
        end

        // R9: display off requested mid-frame, honoured at boundary
        tick_once(); tick_once();
        disp_off = 1'b1;
        cfg_write(rand_map(), 1'b1);
        for (int i = 0; i < 12; i++) begin
            tick_once();
            check_all("R9 off request");
        end
        disp_off = 1'b0;
        for (int i = 0; i < 12; i++) begin
            tick_once();
            check_all("R9 wake");
        end

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            int act;
            act = int'($urandom_range(0, 9));
            if (act < 6)       tick_once();
            else if (act == 6) cfg_write(rand_map(), 1'($urandom_range(0, 1)));
            else if (act == 7) begin disp_off = ($urandom_range(0, 3) == 0); idle(1); end
            else               idle(int'($urandom_range(1, 3)));
            check_all("R2 R8 R9 R10 random");
        end

        // Reset mid-run returns to blank (R1)
        rst_n = 1'b0;
        idle(2);
        m_mode = 0; m_step = 0;
        m_pend = '0; m_act = '0; m_pthird = 1'b0; m_athird = 1'b0;
        check_all("R1 re-reset");
        rst_n = 1'b1;
        disp_off = 1'b1;
        idle(1);
        tick_once();
        check_all("R9 start into off");
        finish_run();
    end

endmodule